// File: doc/BRIEF.md
# Ternary Census Signature Generator

This block turns a raster stream of filtered 8-bit pixels into a stream of 32-bit census signatures. For each pixel whose 5×5 neighbourhood lies wholly inside the frame, the centre value is compared with the sixteen pixels on the outer ring of that neighbourhood. Each comparison yields a three-way code: above, below, or inside a dead band of ±eps around the centre. The sixteen 2-bit codes are packed into one signature word that later stages use to match pixels between frames.

Pixels arrive one per accepted cycle with a valid strobe. A start-of-frame strobe marks the top-left pixel. Four rows of line storage are held inside the block, together with a 5×5 window register. The dead-band width eps is a static input that stays stable while a frame is processed. Output signatures come out in raster order of their centres, each marked by its own valid strobe.

Top module: `census_sig_gen`

## Requirements
- R1: A ring neighbour strictly greater than min(centre+eps, 255) gives code 2 (binary 10).
- R2: A ring neighbour strictly less than max(centre−eps, 0) gives code 1 (binary 01).
- R3: A ring neighbour that meets neither R1 nor R2, including one equal to either bound, gives code 0; code 3 never appears.
- R4: The signature is the concatenation of sixteen codes. Ring point k=1 is in bits [31:30] and point k=16 is in bits [1:0]. The points run clockwise from the top-left corner of the 5×5 window, with (row,col) offsets from the window corner: (0,0),(0,1),(0,2),(0,3),(0,4),(1,4),(2,4),(3,4),(4,4),(4,3),(4,2),(4,1),(4,0),(3,0),(2,0),(1,0). The centre is at (2,2).
- R5: The eight window pixels next to the centre (the inner ring) have no effect on that centre's signature.
- R6: Signatures are produced only for centres whose row and column both lie in [2, dim−3]. There is exactly one signature per such centre, in raster order.
- R7: The bounds centre±eps saturate at 255 and at 0 and never wrap. With eps=255 every code is 0.
- R8: Cycles without valid advance nothing, so gaps in the input stream leave the output sequence unchanged.
- R9: A valid pixel with start-of-frame is taken as row 0, column 0. Rows received before it never take part in later signatures.
- R10: After reset the output valid is low until interior centres have been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_vld | input | 1 | Input pixel valid |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | 8 | Input pixel value |
| eps | input | 8 | Dead-band half width |
| sig_vld | output | 1 | Signature valid |
| sig | output | 32 | Census signature of one centre pixel |

## Verification
A smooth gradient with a small eps gives a mix of above, below and dead-band codes, so a wrong code or a misplaced field shows up. A flat frame with eps 0 isolates the equality case. A single bright pixel sitting on the inner ring of the first centre shows whether inner pixels leak into that centre. A pseudo-random frame fed with idle gaps checks that stalls are harmless. Frames near 255 with large eps expose wrapping bounds. A truncated frame followed by a restart checks the frame-start handling, and the output count of every frame checks the interior rule.

// File: rtl/census_pkg.sv
package census_pkg;
  localparam int PIX_W  = 8;
  localparam int WIN    = 5;
  localparam int HALF   = WIN / 2;
  localparam int RING_N = 16;
  localparam int CODE_W = 2;
  localparam int SIG_W  = RING_N * CODE_W;

  typedef enum logic [CODE_W-1:0] {
    CODE_NEAR  = 2'd0,
    CODE_BELOW = 2'd1,
    CODE_ABOVE = 2'd2
  } tern_e;

  // Upper bound of the dead band, clamped at full scale.
  function automatic logic [PIX_W-1:0] band_hi(input logic [PIX_W-1:0] ctr,
                                               input logic [PIX_W-1:0] dev);
    logic [PIX_W:0] s;
    s = {1'b0, ctr} + {1'b0, dev};
    return s[PIX_W] ? {PIX_W{1'b1}} : s[PIX_W-1:0];
  endfunction

  // Lower bound of the dead band, clamped at zero.
  function automatic logic [PIX_W-1:0] band_lo(input logic [PIX_W-1:0] ctr,
                                               input logic [PIX_W-1:0] dev);
    logic [PIX_W:0] d;
    d = {1'b0, ctr} - {1'b0, dev};
    return d[PIX_W] ? {PIX_W{1'b0}} : d[PIX_W-1:0];
  endfunction

  function automatic tern_e tern_code(input logic [PIX_W-1:0] nb,
                                      input logic [PIX_W-1:0] ctr,
                                      input logic [PIX_W-1:0] dev);
    if (nb > band_hi(ctr, dev))      return CODE_ABOVE;
    else if (nb < band_lo(ctr, dev)) return CODE_BELOW;
    else                             return CODE_NEAR;
  endfunction

  // Ring walk, clockwise from the top-left corner (k is zero based).
  function automatic int ring_row(input int k);
    if (k <= 4)       return 0;
    else if (k <= 8)  return k - 4;
    else if (k <= 12) return 4;
    else              return 16 - k;
  endfunction

  function automatic int ring_col(input int k);
    if (k <= 4)       return k;
    else if (k <= 8)  return 4;
    else if (k <= 12) return 12 - k;
    else              return 0;
  endfunction
endpackage

// File: rtl/census_pos.sv
module census_pos #(
  parameter int IMG_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic                      in_sof,
  output logic [$clog2(IMG_W)-1:0]  cur_col,
  output logic [2:0]                cur_row,
  output logic                      tap_ok
);
  import census_pkg::*;
  localparam int COL_W   = $clog2(IMG_W);
  localparam int ROW_CAP = WIN - 1;

  logic [COL_W-1:0] col_q;
  logic [2:0]       row_q;

  always_comb begin
    cur_col = in_sof ? '0 : col_q;
    cur_row = in_sof ? '0 : row_q;
    tap_ok  = in_vld && (cur_row >= 3'(ROW_CAP)) && (cur_col >= COL_W'(ROW_CAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (in_vld) begin
      if (cur_col == COL_W'(IMG_W - 1)) begin
        col_q <= '0;
        if (cur_row < 3'(ROW_CAP)) row_q <= cur_row + 3'd1;
        else                        row_q <= cur_row;
      end else begin
        col_q <= cur_col + COL_W'(1);
        row_q <= cur_row;
      end
    end
  end

  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_sof) |=> (col_q == COL_W'(1)) && (row_q == 3'd0)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(col_q) && $stable(row_q)); // R8
endmodule

// File: rtl/census_win.sv
module census_win #(
  parameter int IMG_W = 64
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_vld,
  input  logic [census_pkg::PIX_W-1:0]            in_pix,
  input  logic [$clog2(IMG_W)-1:0]                cur_col,
  input  logic                                    tap_ok,
  output logic [census_pkg::PIX_W-1:0]            win [census_pkg::WIN][census_pkg::WIN],
  output logic                                    win_ok
);
  import census_pkg::*;
  localparam int LB_ROWS = WIN - 1;

  logic [PIX_W-1:0] lb [LB_ROWS][IMG_W];
  logic [PIX_W-1:0] col_vec [WIN];

  // Row 0 of the column is the oldest line, row WIN-1 the live pixel.
  always_comb begin
    for (int r = 0; r < LB_ROWS; r++) col_vec[r] = lb[LB_ROWS-1-r][cur_col];
    col_vec[WIN-1] = in_pix;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      lb[0][cur_col] <= in_pix;
      for (int i = 1; i < LB_ROWS; i++) lb[i][cur_col] <= lb[i-1][cur_col];
    end
  end

  genvar gr;
  generate
    for (gr = 0; gr < WIN; gr++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int c = 0; c < WIN; c++) win[gr][c] <= '0;
        end else if (in_vld) begin
          for (int c = 0; c < WIN-1; c++) win[gr][c] <= win[gr][c+1];
          win[gr][WIN-1] <= col_vec[gr];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_ok <= 1'b0;
    else        win_ok <= tap_ok;
  end

  AST_WIN_FROM_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |-> $past(in_vld)); // R8
endmodule

// File: rtl/census_core.sv
module census_core (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [census_pkg::PIX_W-1:0]         win [census_pkg::WIN][census_pkg::WIN],
  input  logic                                 win_ok,
  input  logic [census_pkg::PIX_W-1:0]         eps,
  output logic [census_pkg::SIG_W-1:0]         sig_q,
  output logic                                 sig_vld
);
  import census_pkg::*;

  logic [PIX_W-1:0] ctr;
  logic [PIX_W-1:0] nbv   [RING_N];
  tern_e            codes [RING_N];
  logic [SIG_W-1:0] sig_nxt;

  assign ctr = win[HALF][HALF];

  genvar gk;
  generate
    for (gk = 0; gk < RING_N; gk++) begin : g_ring
      localparam int RR = ring_row(gk);
      localparam int RC = ring_col(gk);
      assign nbv[gk]   = win[RR][RC];
      assign codes[gk] = tern_code(nbv[gk], ctr, eps);
      assign sig_nxt[SIG_W-1-CODE_W*gk -: CODE_W] = codes[gk];

      AST_UP_ABOVE_CTR: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ok && codes[gk] == CODE_ABOVE) |-> (nbv[gk] > ctr)); // R1
      AST_DN_BELOW_CTR: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ok && codes[gk] == CODE_BELOW) |-> (nbv[gk] < ctr)); // R2
      AST_EQ_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ok && nbv[gk] == ctr) |-> (codes[gk] == CODE_NEAR)); // R3
      AST_FULL_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (win_ok && eps == {PIX_W{1'b1}}) |-> (codes[gk] == CODE_NEAR)); // R7
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= '0;
      sig_vld <= 1'b0;
    end else begin
      sig_vld <= win_ok;
      if (win_ok) sig_q <= sig_nxt;
    end
  end
endmodule

// File: rtl/census_sig_gen.sv
module census_sig_gen #(
  parameter int IMG_W = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic        in_sof,
  input  logic [7:0]  in_pix,
  input  logic [7:0]  eps,
  output logic        sig_vld,
  output logic [31:0] sig
);
  import census_pkg::*;
  localparam int COL_W = $clog2(IMG_W);

  logic [COL_W-1:0] cur_col;
  logic [2:0]       cur_row;
  logic             tap_ok;
  logic [PIX_W-1:0] win [WIN][WIN];
  logic             win_ok;

  census_pos #(.IMG_W(IMG_W)) pos_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof),
    .cur_col(cur_col), .cur_row(cur_row), .tap_ok(tap_ok)
  );

  census_win #(.IMG_W(IMG_W)) win_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_pix(in_pix),
    .cur_col(cur_col), .tap_ok(tap_ok), .win(win), .win_ok(win_ok)
  );

  census_core core_i (
    .clk(clk), .rst_n(rst_n), .win(win), .win_ok(win_ok), .eps(eps),
    .sig_q(sig), .sig_vld(sig_vld)
  );

  AST_VLD_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    sig_vld |-> $past(in_vld, 2)); // R6
  AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
    sig_vld |-> ((sig & (sig >> 1) & 32'h5555_5555) == 32'h0)); // R3
endmodule

// File: tb/census_sig_gen_tb_top.sv
module census_sig_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_W = 10;
  localparam int TB_H = 8;
  localparam int N_OUT = (TB_W - 4) * (TB_H - 4);

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_vld = 0;
  logic        in_sof = 0;
  logic [7:0]  in_pix = 0;
  logic [7:0]  eps = 0;
  logic        sig_vld;
  logic [31:0] sig;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  int img [TB_H][TB_W];
  logic [31:0] got [256];
  int ngot = 0;

  census_sig_gen #(.IMG_W(TB_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof),
    .in_pix(in_pix), .eps(eps), .sig_vld(sig_vld), .sig(sig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && sig_vld && ngot < 256) begin
    got[ngot] = sig;
    ngot++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the ternary code with clamped band edges.
  function automatic int tcode(int nb, int c, int e);
    int hi, lo;
    hi = c + e; if (hi > 255) hi = 255;
    lo = c - e; if (lo < 0) lo = 0;
    if (nb > hi) return 2;
    if (nb < lo) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] model_sig(int cr, int cc, int e);
    logic [31:0] s;
    int r, c;
    s = 0;
    for (int k = 0; k < 16; k++) begin
      if (k < 5)       begin r = 0;      c = k;      end
      else if (k < 9)  begin r = k - 4;  c = 4;      end
      else if (k < 13) begin r = 4;      c = 12 - k; end
      else             begin r = 16 - k; c = 0;      end
      s = (s << 2) | 32'(tcode(img[cr-2+r][cc-2+c], img[cr][cc], e));
    end
    return s;
  endfunction

  task automatic drive_pixel(input int p, input bit s);
    in_vld = 1; in_pix = 8'(p); in_sof = s;
    @(negedge clk);
    in_vld = 0; in_sof = 0;
  endtask

  task automatic send_frame(input bit gaps);
    ngot = 0;
    for (int r = 0; r < TB_H; r++)
      for (int c = 0; c < TB_W; c++) begin
        drive_pixel(img[r][c], (r == 0 && c == 0));
        if (gaps && ((r + c) % 3 == 0)) repeat (2) @(negedge clk);
      end
    repeat (6) @(negedge clk);
  endtask

  task automatic check_frame(input string req);
    int i;
    chk(ngot == N_OUT, {req, " R6 count"}, 32'(ngot), 32'(N_OUT));
    i = 0;
    for (int r = 2; r <= TB_H - 3; r++)
      for (int c = 2; c <= TB_W - 3; c++) begin
        if (i < ngot)
          chk(got[i] === model_sig(r, c, int'(eps)), req, got[i], model_sig(r, c, int'(eps)));
        i++;
      end
  endtask

  task automatic t_reset;
    chk(sig_vld === 1'b0, "R10 reset valid", 32'(sig_vld), 0);
    chk(sig === 32'h0, "R10 reset sig", sig, 0);
  endtask

  task automatic t_gradient;
    for (int r = 0; r < TB_H; r++)
      for (int c = 0; c < TB_W; c++) img[r][c] = (r * 20 + c * 3 + ((r * c) % 7)) % 256;
    eps = 8'd4;
    send_frame(0);
    check_frame("R1 R2 R4 gradient");
  endtask

  task automatic t_flat;
    for (int r = 0; r < TB_H; r++)
      for (int c = 0; c < TB_W; c++) img[r][c] = 100;
    img[4][5] = 103;
    eps = 8'd0;
    send_frame(0);
    check_frame("R3 flat eps0");
    eps = 8'd3;
    send_frame(0);
    check_frame("R3 bound equal");
    chk(got[0] === 32'h0, "R3 centre(2,2) all near", got[0], 32'h0);
  endtask

  task automatic t_inner;
    for (int r = 0; r < TB_H; r++)
      for (int c = 0; c < TB_W; c++) img[r][c] = 100;
    img[3][3] = 200;
    eps = 8'd5;
    send_frame(0);
    chk(got[0] === 32'h0, "R5 inner ring ignored", got[0], 32'h0);
    check_frame("R5 inner frame");
  endtask

  task automatic t_random_gaps;
    int v;
    v = 37;
    for (int r = 0; r < TB_H; r++)
      for (int c = 0; c < TB_W; c++) begin
        v = (v * 75 + 74) % 65537;
        img[r][c] = v % 256;
      end
    eps = 8'd10;
    send_frame(1);
    check_frame("R8 gaps");
  endtask

  task automatic t_saturate;
    for (int r = 0; r < TB_H; r++)
      for (int c = 0; c < TB_W; c++) img[r][c] = 250;
    img[2][2] = 255;
    eps = 8'd10;
    send_frame(0);
    check_frame("R7 high clamp");
    chk(got[0] === 32'h0, "R7 no wrap top", got[0], 32'h0);
    for (int r = 0; r < TB_H; r++)
      for (int c = 0; c < TB_W; c++) img[r][c] = ((r + c) % 2) ? 255 : 3;
    eps = 8'd255;
    send_frame(0);
    check_frame("R7 eps255");
    eps = 8'd6;
    send_frame(0);
    check_frame("R7 low clamp");
  endtask

  task automatic t_restart;
    ngot = 0;
    for (int i = 0; i < 2 * TB_W + 4; i++) drive_pixel(255 - i, (i == 0));
    for (int r = 0; r < TB_H; r++)
      for (int c = 0; c < TB_W; c++) img[r][c] = (r * 31 + c * 17) % 256;
    eps = 8'd8;
    send_frame(0);
    check_frame("R9 restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gradient();
    t_flat();
    t_inner();
    t_random_gaps();
    t_saturate();
    t_restart();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule